// File: doc/BRIEF.md
# Comma-Aligned Receive Deserializer

This block takes a retimed serial bit stream per channel, one bit per bit-clock cycle, and rebuilds 10-bit characters from it. Each character leaves the block as two 5-bit halves on a double-data-rate bus. The low half (bits 0 to 4) is presented first and the high half (bits 5 to 9) second, so the first bit received always lands on lane 0. Every channel also drives a pair of complementary byte clocks that run at one tenth of the bit rate. Their edges fall in the middle of each half, so a downstream device can capture both halves on either edge of either clock.

While the alignment enable is high, each channel looks for the positive-disparity comma in a sliding window of the last ten received bits. A comma that straddles the current character boundary makes the channel move its boundary by freezing its bit counter. The byte-clock phase in progress is therefore only ever lengthened, and the period that contains the shift lasts 11 to 19 bit times. The next comma then leaves the block whole, with its first bit on lane 0, and the per-channel sync flag is high for that character's slot. While the enable is low, the framing and the clocks carry on untouched and the sync flags stay low.

Top module: `rxd_comma_deser`

## Requirements
- R1: A comma is recognised only when the first seven bits of a 10-bit window, in receive order, are 0,0,1,1,1,1,1 (bit 0 first), whatever bits 7 to 9 hold. Patterns that differ in any of those seven bits neither realign the channel nor raise its sync flag.
- R2: Bit i of an output character is the i-th bit received in that character. The first half carries bits 0 to 4 and the second half carries bits 5 to 9, so lane k of `rx_half` shows bit k and then bit k+5.
- R3: While `sync_en` is low, no realignment takes place: every byte-clock period stays exactly 10 bit clocks, and `sync_flag` stays low even when comma patterns arrive.
- R4: With `sync_en` high, a comma that arrives off the current boundary moves the boundary. The next comma, received a multiple of ten bits later, leaves the block as one character whose first bit is on lane 0 of the first half, and the character after it is framed correctly.
- R5: No byte-clock high or low phase is shorter than 5 bit clocks. A realignment lengthens exactly one period, to between 11 and 19 bit clocks.
- R6: `rx_half` never changes in the bit-clock cycle in which a byte clock toggles. The primary clock rises CLK_LEAD bit clocks after the first half is presented, and falls CLK_LEAD bit clocks after the second half is presented.
- R7: `byte_clk_n` is always the complement of `byte_clk_p`, and an unstretched period is 10 bit clocks.
- R8: `sync_flag` is high for the whole slot of an output character whose first seven bits match the comma, provided `sync_en` was high at that character's boundary. It is low for every other character.
- R9: During reset `byte_clk_p` is 0, `byte_clk_n` is 1, `rx_half` is 0 and `sync_flag` is 0, and the first low phase after reset has full length.
- R10: Channels frame independently: each one aligns to its own comma position, whatever the bit offset of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle on each channel |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Enables comma detection, realignment and sync flags on all channels |
| ser_in | input | CHANNELS | Retimed serial bit, one per channel |
| rx_half | output | 5*CHANNELS | Current 5-bit half per channel; channel c on bits [5c+4:5c], lane 0 in the low bit |
| byte_clk_p | output | CHANNELS | Primary byte clock per channel; rises within the first half |
| byte_clk_n | output | CHANNELS | Secondary byte clock per channel, 180 degrees from the primary |
| sync_flag | output | CHANNELS | High for the slot of an output character that matched the comma |

## Verification
The bench builds the block with CHANNELS=2, CHAR_W=10 and CLK_LEAD=3. With two channels, each stream in the table can give the channels different leading bit offsets, so framing independence and every freeze length from 1 to 9 cycles are reached within one run. A CLK_LEAD of 3 leaves unequal margins (3 and 2 bit clocks) around each clock edge, which makes any drift in the position of a half-switch visible as a change in `rx_half` on an edge cycle. The directed tests then cover near-miss comma patterns, commas sent with the enable low, and a reset in the middle of traffic.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   // Only the leading bits of a character take part in comma recognition.
   localparam int MATCH_BITS = 7;
   // Received order bit0..bit6 = 0,0,1,1,1,1,1 (bit 0 in the LSB).
   localparam logic [MATCH_BITS-1:0] COMMA_HEAD = 7'b1111100;
   // Character width the comma definition belongs to.
   localparam int COMMA_CHAR_W = 10;
endpackage

// File: rtl/rxd_window.sv
module rxd_window #(
   parameter int CHAR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser,
   output logic [CHAR_W-1:0] win_next,
   output logic              comma_hit
);
   localparam int HIST_W = CHAR_W - 1;

   logic [HIST_W-1:0] hist_q;

   // Oldest bit in the LSB: win_next[0] is the first bit of the window.
   assign win_next  = {ser, hist_q};
   assign comma_hit = (win_next[rxd_pkg::MATCH_BITS-1:0] == rxd_pkg::COMMA_HEAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= win_next[CHAR_W-1:1];
   end
endmodule

// File: rtl/rxd_framer.sv
module rxd_framer #(
   parameter int CHAR_W   = 10,
   parameter int CLK_LEAD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_en,
   input  logic comma_hit,
   output logic boundary,
   output logic upper_half,
   output logic clk_p,
   output logic clk_n
);
   localparam int CW   = $clog2(CHAR_W);
   localparam int HALF = CHAR_W / 2;
   localparam logic [CW-1:0] LAST_V = CW'(CHAR_W - 1);
   localparam logic [CW-1:0] RISE_V = CW'(CLK_LEAD);
   localparam logic [CW-1:0] FALL_V = CW'(CLK_LEAD + HALF);
   localparam logic [CW-1:0] HALF_V = CW'(HALF);

   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW-1:0] hold_q, hold_d;
   logic          at_last, in_hold, p_next;

   assign at_last = (cnt_q == LAST_V);
   assign in_hold = (hold_q != '0);

   // A misaligned comma freezes the counter for cnt_q+1 cycles in total, which
   // puts the next boundary exactly one character after the comma.
   always_comb begin
      cnt_d    = cnt_q;
      hold_d   = hold_q;
      boundary = 1'b0;
      if (in_hold) begin
         hold_d = hold_q - CW'(1);
      end else if (at_last) begin
         cnt_d    = '0;
         boundary = 1'b1;
      end else if (sync_en && comma_hit) begin
         hold_d = cnt_q;
      end else begin
         cnt_d = cnt_q + CW'(1);
      end
   end

   assign p_next     = (cnt_d >= RISE_V) && (cnt_d < FALL_V);
   assign upper_half = (cnt_d >= HALF_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= FALL_V;
         hold_q <= '0;
         clk_p  <= 1'b0;
         clk_n  <= 1'b1;
      end else begin
         cnt_q  <= cnt_d;
         hold_q <= hold_d;
         clk_p  <= p_next;
         clk_n  <= !p_next;
      end
   end
endmodule

// File: rtl/rxd_ddr_out.sv
module rxd_ddr_out #(
   parameter int CHAR_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sync_en,
   input  logic                boundary,
   input  logic                upper_half,
   input  logic                comma_hit,
   input  logic [CHAR_W-1:0]   win_next,
   output logic [CHAR_W/2-1:0] half_o,
   output logic                sync_o
);
   localparam int HALF = CHAR_W / 2;

   logic [CHAR_W-1:0] char_q, char_d;

   assign char_d = boundary ? win_next : char_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_q <= '0;
         half_o <= '0;
         sync_o <= 1'b0;
      end else begin
         char_q <= char_d;
         half_o <= upper_half ? char_d[CHAR_W-1:HALF] : char_d[HALF-1:0];
         if (boundary) sync_o <= comma_hit && sync_en;
      end
   end
endmodule

// File: rtl/rxd_comma_deser.sv
module rxd_comma_deser #(
   parameter int CHANNELS = 2,
   parameter int CHAR_W   = 10,
   parameter int CLK_LEAD = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           sync_en,
   input  logic [CHANNELS-1:0]            ser_in,
   output logic [CHANNELS*(CHAR_W/2)-1:0] rx_half,
   output logic [CHANNELS-1:0]            byte_clk_p,
   output logic [CHANNELS-1:0]            byte_clk_n,
   output logic [CHANNELS-1:0]            sync_flag
);
   localparam int HALF = CHAR_W / 2;

   if (CHAR_W != rxd_pkg::COMMA_CHAR_W) begin : g_bad_width
      $error("CHAR_W must match the comma character width");
   end
   if (CHANNELS < 1) begin : g_bad_channels
      $error("CHANNELS must be at least 1");
   end
   if (CLK_LEAD < 1 || CLK_LEAD >= HALF) begin : g_bad_lead
      $error("CLK_LEAD must lie strictly inside a half");
   end

   for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
      logic [CHAR_W-1:0] win_next;
      logic              hit, bnd, upper;

      rxd_window #(.CHAR_W(CHAR_W)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .ser      (ser_in[g]),
         .win_next (win_next),
         .comma_hit(hit)
      );

      rxd_framer #(.CHAR_W(CHAR_W), .CLK_LEAD(CLK_LEAD)) u_frm (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_en   (sync_en),
         .comma_hit (hit),
         .boundary  (bnd),
         .upper_half(upper),
         .clk_p     (byte_clk_p[g]),
         .clk_n     (byte_clk_n[g])
      );

      rxd_ddr_out #(.CHAR_W(CHAR_W)) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_en   (sync_en),
         .boundary  (bnd),
         .upper_half(upper),
         .comma_hit (hit),
         .win_next  (win_next),
         .half_o    (rx_half[g*HALF +: HALF]),
         .sync_o    (sync_flag[g])
      );
   end
endmodule

// File: rtl/rxd_comma_deser_chk.sv
module rxd_comma_deser_chk #(
   parameter int CHANNELS = 2,
   parameter int CHAR_W   = 10
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           sync_en,
   input logic [CHANNELS*(CHAR_W/2)-1:0] rx_half,
   input logic [CHANNELS-1:0]            byte_clk_p,
   input logic [CHANNELS-1:0]            byte_clk_n,
   input logic [CHANNELS-1:0]            sync_flag
);
   localparam int HALF = CHAR_W / 2;
   localparam logic [HALF-1:0] COMMA_LO = rxd_pkg::COMMA_HEAD[HALF-1:0];

   for (genvar g = 0; g < CHANNELS; g++) begin : g_a
      logic       lvl_q;
      logic [7:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
         end else if (byte_clk_p[g] != lvl_q) begin
            lvl_q <= byte_clk_p[g];
            run_q <= 8'd1;
         end else if (run_q != 8'hFF) begin
            run_q <= run_q + 8'd1;
         end
      end

      // R5: a level change only after a full-length phase
      p_no_sliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_clk_p[g] != lvl_q) |-> (run_q >= 8'(HALF)));

      // R7: the clock pair stays complementary
      p_clk_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
         byte_clk_n[g] == !byte_clk_p[g]);

      // R6: data does not move on a byte-clock edge cycle
      p_edge_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(byte_clk_p[g]) || $fell(byte_clk_p[g])) |-> $stable(rx_half[g*HALF +: HALF]));

      // R3: a flag is only raised from an enabled boundary
      p_flag_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sync_flag[g]) |-> $past(sync_en));

      // R4: a flagged character starts with the comma on lane 0
      p_comma_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sync_flag[g]) |-> (rx_half[g*HALF +: HALF] == COMMA_LO));
   end
endmodule

bind rxd_comma_deser rxd_comma_deser_chk #(.CHANNELS(CHANNELS), .CHAR_W(CHAR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_en   (sync_en),
   .rx_half   (rx_half),
   .byte_clk_p(byte_clk_p),
   .byte_clk_n(byte_clk_n),
   .sync_flag (sync_flag)
);

// File: tb/tb_rxd_comma_deser.sv
module tb_rxd_comma_deser;
   localparam int CH = 2;
   localparam int CW = 10;
   localparam int HW = 5;
   localparam logic [6:0] HEAD = 7'b1111100;
   localparam logic [CW-1:0] DMASK = ~10'b0010000100;  // keeps data free of 5-runs of ones

   // entry = {x1[10], x0[10], tail[3], off1[5], off0[5]}
   localparam int NV = 6;
   localparam logic [32:0] VEC [NV] = '{
      {10'h2B5, 10'h0C3, 3'b010, 5'd3,  5'd0},
      {10'h319, 10'h26E, 3'b000, 5'd12, 5'd7},
      {10'h04F, 10'h35A, 3'b111, 5'd1,  5'd9},
      {10'h1E3, 10'h0B1, 3'b101, 5'd19, 5'd14},
      {10'h37C, 10'h11D, 3'b110, 5'd5,  5'd5},
      {10'h0D6, 10'h3A9, 3'b011, 5'd2,  5'd11}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_en = 1'b0;
   logic [CH-1:0] ser_in = '0;
   logic [CH*HW-1:0] rx_half;
   logic [CH-1:0] byte_clk_p, byte_clk_n, sync_flag;

   always #5 clk = ~clk;

   rxd_comma_deser #(.CHANNELS(CH), .CHAR_W(CW), .CLK_LEAD(3)) dut (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .ser_in(ser_in),
      .rx_half(rx_half), .byte_clk_p(byte_clk_p), .byte_clk_n(byte_clk_n),
      .sync_flag(sync_flag)
   );

   int checks = 0, failures = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- monitor ----------------
   logic          prev_p [CH];
   logic [HW-1:0] prev_h [CH];
   logic [HW-1:0] lo_h   [CH];
   logic          lo_s   [CH];
   bit            have_rise [CH], seen_lo [CH], want_after [CH];
   int            run [CH], since_rise [CH], n_sync [CH];
   logic [CW-1:0] sync_char [CH], after_char [CH];
   int g_min_phase = 99, g_min_period = 99, g_max_period = 0, g_stretched = 0;
   int bad_pair = 0, bad_stable = 0, bad_sync = 0, w_stretched = 0;

   always @(negedge clk) begin
      for (int i = 0; i < CH; i++) begin
         automatic logic [HW-1:0] h;
         automatic logic [CW-1:0] cv;
         h = rx_half[i*HW +: HW];
         if (!rst_n) begin
            prev_p[i] = 1'b0; prev_h[i] = '0; run[i] = 0; since_rise[i] = 0;
            have_rise[i] = 1'b0; seen_lo[i] = 1'b0;
         end else begin
            if (byte_clk_n[i] !== ~byte_clk_p[i]) bad_pair++;
            if (byte_clk_p[i] != prev_p[i]) begin
               if (h != prev_h[i]) bad_stable++;
               if (run[i] < g_min_phase) g_min_phase = run[i];
               run[i] = 1;
               if (byte_clk_p[i]) begin
                  if (have_rise[i]) begin
                     if (since_rise[i] < g_min_period) g_min_period = since_rise[i];
                     if (since_rise[i] > g_max_period) g_max_period = since_rise[i];
                     if (since_rise[i] > CW) begin g_stretched++; w_stretched++; end
                  end
                  have_rise[i] = 1'b1; since_rise[i] = 0;
                  lo_h[i] = h; lo_s[i] = sync_flag[i]; seen_lo[i] = 1'b1;
               end else if (seen_lo[i]) begin
                  cv = {h, lo_h[i]};
                  if (want_after[i]) begin after_char[i] = cv; want_after[i] = 1'b0; end
                  if (lo_s[i]) begin
                     n_sync[i]++; sync_char[i] = cv; want_after[i] = 1'b1;
                     if (cv[6:0] != HEAD) bad_sync++;
                  end
               end
            end else begin
               run[i]++;
            end
            since_rise[i]++;
            prev_p[i] = byte_clk_p[i];
            prev_h[i] = h;
         end
      end
   end

   // ---------------- stream building ----------------
   logic sbit [CH][512];
   int   slen [CH];

   task automatic push(input int c, input logic [CW-1:0] v);
      for (int k = 0; k < CW; k++) begin sbit[c][slen[c]] = v[k]; slen[c]++; end
   endtask

   task automatic junk(input int c, input int n);
      for (int k = 0; k < n; k++) begin sbit[c][slen[c]] = k[0]; slen[c]++; end
   endtask

   task automatic send_all();
      int m = 0;
      for (int c = 0; c < CH; c++) if (slen[c] > m) m = slen[c];
      for (int k = 0; k < m + 12; k++) begin
         @(negedge clk);
         for (int c = 0; c < CH; c++) ser_in[c] = (k < slen[c]) ? sbit[c][k] : k[0];
      end
   endtask

   task automatic clear_window();
      @(posedge clk);
      w_stretched = 0;
      for (int c = 0; c < CH; c++) begin
         slen[c] = 0; n_sync[c] = 0; want_after[c] = 1'b0;
         sync_char[c] = '0; after_char[c] = '0;
      end
   endtask

   task automatic run_vec(input logic [32:0] v);
      logic [CW-1:0] comma, xs [CH];
      int offs [CH];
      comma = {v[12:10], HEAD};
      offs[0] = int'(v[4:0]); offs[1] = int'(v[9:5]);
      xs[0] = v[22:13] & DMASK; xs[1] = v[32:23] & DMASK;
      clear_window();
      for (int c = 0; c < CH; c++) begin
         junk(c, offs[c]);
         push(c, comma);
         push(c, 10'h155 & DMASK);
         push(c, 10'h2D3 & DMASK);
         push(c, comma);
         push(c, xs[c]);
         push(c, 10'h0E9 & DMASK);
         push(c, 10'h36C & DMASK);
         push(c, 10'h1A5 & DMASK);
      end
      send_all();
      for (int c = 0; c < CH; c++) begin
         chk(n_sync[c] >= 1, "R8 comma flagged", n_sync[c], 1);
         chk(sync_char[c] == comma, "R1 R4 flagged character is the whole comma", int'(sync_char[c]), int'(comma));
         chk(after_char[c] == xs[c], (c == 0) ? "R2 R4 framing after comma" : "R10 R2 framing on second channel",
             int'(after_char[c]), int'(xs[c]));
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(byte_clk_p == '0, "R9 primary clock in reset", int'(byte_clk_p), 0);
      chk(byte_clk_n == '1, "R9 secondary clock in reset", int'(byte_clk_n), 3);
      chk(rx_half == '0, "R9 data in reset", int'(rx_half), 0);
      chk(sync_flag == '0, "R9 flag in reset", int'(sync_flag), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      sync_en = 1'b1;

      for (int n = 0; n < NV; n++) run_vec(VEC[n]);

      // R1: near-miss patterns must neither stretch nor flag
      clear_window();
      for (int c = 0; c < CH; c++) begin
         junk(c, 4 + 3 * c);
         push(c, {3'b101, 7'b0111100});
         push(c, 10'h155 & DMASK);
         push(c, {3'b010, 7'b1111101});
         push(c, 10'h2D3 & DMASK);
         push(c, 10'h0E9 & DMASK);
         push(c, 10'h36C & DMASK);
      end
      send_all();
      chk(w_stretched == 0, "R1 near miss caused no realignment", w_stretched, 0);
      chk(n_sync[0] + n_sync[1] == 0, "R1 near miss raised no flag", n_sync[0] + n_sync[1], 0);

      // R3: enable low, commas at two different offsets
      @(negedge clk); sync_en = 1'b0;
      clear_window();
      for (int c = 0; c < CH; c++) begin
         junk(c, 6 + c);
         push(c, {3'b010, HEAD});
         push(c, 10'h155 & DMASK);
         junk(c, 3);
         push(c, {3'b010, HEAD});
         push(c, 10'h2D3 & DMASK);
         push(c, 10'h0E9 & DMASK);
         push(c, 10'h36C & DMASK);
      end
      send_all();
      chk(w_stretched == 0, "R3 no realignment while disabled", w_stretched, 0);
      chk(n_sync[0] + n_sync[1] == 0, "R3 no flag while disabled", n_sync[0] + n_sync[1], 0);
      @(negedge clk); sync_en = 1'b1;
      run_vec(VEC[1]);

      // R9: reset in the middle of traffic
      @(posedge clk); #1 rst_n = 1'b0;
      @(negedge clk);
      chk(byte_clk_p == '0 && byte_clk_n == '1, "R9 clocks after mid-run reset",
          int'({byte_clk_p, byte_clk_n}), 3);
      chk(rx_half == '0 && sync_flag == '0, "R9 outputs after mid-run reset",
          int'({rx_half, sync_flag}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      run_vec(VEC[3]);

      chk(g_min_phase >= HW, "R5 shortest byte-clock phase", g_min_phase, HW);
      chk(g_stretched > 0, "R5 realignment stretched a period", g_stretched, 1);
      chk(g_max_period <= 2 * CW - 1, "R5 longest stretched period", g_max_period, 2 * CW - 1);
      chk(g_min_period == CW, "R7 nominal byte-clock period", g_min_period, CW);
      chk(bad_pair == 0, "R7 clock pair complementary", bad_pair, 0);
      chk(bad_stable == 0, "R6 data stable at clock edges", bad_stable, 0);
      chk(bad_sync == 0, "R8 flag only on comma characters", bad_sync, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule